// File: doc/BRIEF.md
# Five-Channel DMA Engine with Priority Arbitration

This block moves data words without processor involvement over a single shared bus master port. Each of its five channels holds its own source and destination word addresses, a 16-bit item count, a transfer direction, a two-bit priority level, separate increment enables for the two addresses, a circular enable and three interrupt enables. One item is one single-beat read from the current source address followed by one single-beat write of that word to the current destination address.

Peripheral-paced channels (peripheral to memory, memory to peripheral) move one item for each hardware request and return a one-cycle acknowledge as the item's write completes. Memory-to-memory channels run continuously once enabled. When several channels are ready at once, an arbiter picks the highest programmed level, and the lowest channel number among equal levels. Each channel keeps three sticky event flags: half-way, finished and bus error. Each flag can be set or cleared from outside, and each can raise the channel's interrupt line through its own enable.

Software programs a channel through a word-wide write port. The port selects a channel and one of four fields: source address, destination address, count and control.

Top module: `dma5_engine`

## Requirements
- R1: During and after reset, no bus access is made (`m_valid` low), and every flag, interrupt and channel enable reads 0.
- R2: A write with `cfg_sel`=0 loads the source base and current source address. `cfg_sel`=1 does the same for the destination. `cfg_sel`=2 loads the count reload and remaining count. `cfg_sel`=3 loads control: bit 0 enable, bits 2:1 direction (0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory), bits 4:3 priority, bit 5 source increment, bit 6 destination increment, bit 7 circular, bits 10:8 interrupt enables (half, done, error).
- R3: A peripheral-paced channel moves exactly one item per pending request, and with no request it makes no access. `dack[c]` pulses for one cycle as that item's write is accepted. A memory-to-memory channel needs no request.
- R4: An item reads the current source address, then writes the word read to the current destination address. `m_valid`, `m_addr` and `m_we` stay stable until `m_ready`.
- R5: Among ready channels, the highest priority level is served first. Among equal levels, the lower channel number is served first. Only one channel uses the bus at a time.
- R6: After each item, an enabled increment adds one word to its address. A cleared increment keeps the address fixed. Source and destination are independent.
- R7: A channel with a remaining count of 0 makes no access. When the count reaches 0 in non-circular mode, the done flag sets and the channel enable clears.
- R8: The half flag sets on the item after which the remaining count equals the programmed count divided by two, rounded down.
- R9: In circular mode, reaching 0 sets the done flag, reloads the count and both addresses from their programmed values, and the channel keeps running.
- R10: An error response sets that channel's error flag, clears its enable and ends the item without its write. Other channels continue unaffected.
- R11: Flags of channel c sit at `flags[3c]` (half), `flags[3c+1]` (done) and `flags[3c+2]` (error). `flag_set` and `flag_clr` set and clear them, with set winning. `irq[c]` is high when any flag of c and its enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Field write strobe |
| cfg_ch | input | 3 | Channel number for the write |
| cfg_sel | input | 2 | Field select |
| cfg_wdata | input | 32 | Field write value |
| flag_set | input | 15 | Per-flag set strobes |
| flag_clr | input | 15 | Per-flag clear strobes |
| dreq | input | 5 | Hardware request per channel |
| dack | output | 5 | One-cycle acknowledge per served request |
| m_valid | output | 1 | Bus access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Word address |
| m_wdata | output | 32 | Write data |
| m_ready | input | 1 | Access accepted this cycle |
| m_rdata | input | 32 | Read data, valid with `m_ready` |
| m_err | input | 1 | Error response, valid with `m_ready` |
| flags | output | 15 | Event flags, three per channel |
| irq | output | 5 | Interrupt per channel |
| chan_en | output | 5 | Channel enable state |

## Verification
The bench targets the boundaries of the count. It stops a paced channel after the first half of its requests, where an off-by-one comparison would set the half flag one item early or late. It also programs a zero count, which a design that decrements before testing would wrap into 65535 accesses. Simultaneous requests on four channels with two tied levels expose a tie-break that favours the higher number, or a priority compare that ignores the level. A circular run across several wraps catches a reload that forgets the addresses, which would keep stepping past the block. An error injected mid-run on one channel, while a second channel runs, catches a design that writes the bad word or halts the bus for everyone.

// File: rtl/dma5_pkg.sv
package dma5_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xstate_e;

  localparam int NFLAG   = 3;
  localparam int FL_HALF = 0;
  localparam int FL_DONE = 1;
  localparam int FL_ERR  = 2;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_PRIO = 3;
  localparam int CB_SINC = 5;
  localparam int CB_DINC = 6;
  localparam int CB_CIRC = 7;
  localparam int CB_IE   = 8;

endpackage

// File: rtl/dma5_chan.sv
module dma5_chan
  import dma5_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int PW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             hw_req,
  input  logic             step,
  input  logic             fail,
  input  logic [NFLAG-1:0] flag_set,
  input  logic [NFLAG-1:0] flag_clr,
  output logic             elig_o,
  output logic [PW-1:0]    prio_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o,
  output logic             en_o
);

  logic [AW-1:0]    src_base_q, src_base_d, dst_base_q, dst_base_d;
  logic [AW-1:0]    src_cur_q, src_cur_d, dst_cur_q, dst_cur_d;
  logic [CW-1:0]    cnt_rld_q, cnt_rld_d, cnt_cur_q, cnt_cur_d;
  logic [CW-1:0]    cnt_dec;
  logic             en_q, en_d, sinc_q, sinc_d, dinc_q, dinc_d, circ_q, circ_d;
  dir_e             dir_q, dir_d;
  logic [PW-1:0]    prio_q, prio_d;
  logic [NFLAG-1:0] ie_q, ie_d, fl_q, fl_d;
  logic             upd;

  assign cnt_dec = cnt_cur_q - CW'(1);
  assign upd     = cfg_we | step | fail | (|flag_set) | (|flag_clr);

  always_comb begin
    src_base_d = src_base_q;
    dst_base_d = dst_base_q;
    src_cur_d  = src_cur_q;
    dst_cur_d  = dst_cur_q;
    cnt_rld_d  = cnt_rld_q;
    cnt_cur_d  = cnt_cur_q;
    en_d       = en_q;
    dir_d      = dir_q;
    prio_d     = prio_q;
    sinc_d     = sinc_q;
    dinc_d     = dinc_q;
    circ_d     = circ_q;
    ie_d       = ie_q;
    fl_d       = fl_q;
    if (step) begin
      cnt_cur_d = cnt_dec;
      if (sinc_q) src_cur_d = src_cur_q + AW'(1);
      if (dinc_q) dst_cur_d = dst_cur_q + AW'(1);
      if (cnt_dec == (cnt_rld_q >> 1)) fl_d[FL_HALF] = 1'b1;
      if (cnt_dec == '0) begin
        fl_d[FL_DONE] = 1'b1;
        if (circ_q) begin
          cnt_cur_d = cnt_rld_q;
          src_cur_d = src_base_q;
          dst_cur_d = dst_base_q;
        end else begin
          en_d = 1'b0;
        end
      end
    end
    if (fail) begin
      fl_d[FL_ERR] = 1'b1;
      en_d         = 1'b0;
    end
    fl_d = (fl_d & ~flag_clr) | flag_set;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_SRC: begin
          src_base_d = cfg_wdata;
          src_cur_d  = cfg_wdata;
        end
        SEL_DST: begin
          dst_base_d = cfg_wdata;
          dst_cur_d  = cfg_wdata;
        end
        SEL_CNT: begin
          cnt_rld_d = cfg_wdata[CW-1:0];
          cnt_cur_d = cfg_wdata[CW-1:0];
        end
        default: begin
          en_d   = cfg_wdata[CB_EN];
          dir_d  = dir_e'(cfg_wdata[CB_DIR +: 2]);
          prio_d = cfg_wdata[CB_PRIO +: PW];
          sinc_d = cfg_wdata[CB_SINC];
          dinc_d = cfg_wdata[CB_DINC];
          circ_d = cfg_wdata[CB_CIRC];
          ie_d   = cfg_wdata[CB_IE +: NFLAG];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base_q <= '0;
      dst_base_q <= '0;
      src_cur_q  <= '0;
      dst_cur_q  <= '0;
      cnt_rld_q  <= '0;
      cnt_cur_q  <= '0;
      en_q       <= 1'b0;
      dir_q      <= DIR_P2M;
      prio_q     <= '0;
      sinc_q     <= 1'b0;
      dinc_q     <= 1'b0;
      circ_q     <= 1'b0;
      ie_q       <= '0;
      fl_q       <= '0;
    end else if (upd) begin
      src_base_q <= src_base_d;
      dst_base_q <= dst_base_d;
      src_cur_q  <= src_cur_d;
      dst_cur_q  <= dst_cur_d;
      cnt_rld_q  <= cnt_rld_d;
      cnt_cur_q  <= cnt_cur_d;
      en_q       <= en_d;
      dir_q      <= dir_d;
      prio_q     <= prio_d;
      sinc_q     <= sinc_d;
      dinc_q     <= dinc_d;
      circ_q     <= circ_d;
      ie_q       <= ie_d;
      fl_q       <= fl_d;
    end
  end

  assign elig_o  = en_q && (cnt_cur_q != '0) && ((dir_q == DIR_M2M) || hw_req);
  assign prio_o  = prio_q;
  assign src_o   = src_cur_q;
  assign dst_o   = dst_cur_q;
  assign flags_o = fl_q;
  assign irq_o   = |(fl_q & ie_q);
  assign en_o    = en_q;

endmodule

// File: rtl/dma5_arb.sv
module dma5_arb #(
  parameter int NCH = 5,
  parameter int PW  = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig_i,
  input  logic [PW-1:0]  prio_i [NCH],
  output logic           gnt_valid,
  output logic [IW-1:0]  gnt_idx
);

  logic [PW-1:0] best;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    best      = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig_i[i] && (!gnt_valid || (prio_i[i] >= best))) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(i);
        best      = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/dma5_xfer.sv
module dma5_xfer
  import dma5_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gnt_valid,
  input  logic [IW-1:0]  gnt_idx,
  input  logic [AW-1:0]  src_i [NCH],
  input  logic [AW-1:0]  dst_i [NCH],
  output logic           m_valid,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_ready,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_err,
  output logic [NCH-1:0] step_o,
  output logic [NCH-1:0] fail_o
);

  xstate_e       st_q, st_d;
  logic [IW-1:0] ch_q, ch_d;
  logic [AW-1:0] raddr_q, raddr_d, waddr_q, waddr_d;
  logic [DW-1:0] data_q, data_d;
  logic          ce;

  always_comb begin
    st_d    = st_q;
    ch_d    = ch_q;
    raddr_d = raddr_q;
    waddr_d = waddr_q;
    data_d  = data_q;
    unique case (st_q)
      XS_IDLE: begin
        if (gnt_valid) begin
          st_d    = XS_READ;
          ch_d    = gnt_idx;
          raddr_d = src_i[gnt_idx];
          waddr_d = dst_i[gnt_idx];
        end
      end
      XS_READ: begin
        if (m_ready) begin
          if (m_err) begin
            st_d = XS_IDLE;
          end else begin
            st_d   = XS_WRITE;
            data_d = m_rdata;
          end
        end
      end
      default: begin
        if (m_ready) st_d = XS_IDLE;
      end
    endcase
  end

  assign ce = (st_q == XS_IDLE) ? gnt_valid : m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      ch_q    <= '0;
      raddr_q <= '0;
      waddr_q <= '0;
      data_q  <= '0;
    end else if (ce) begin
      st_q    <= st_d;
      ch_q    <= ch_d;
      raddr_q <= raddr_d;
      waddr_q <= waddr_d;
      data_q  <= data_d;
    end
  end

  assign m_valid = (st_q != XS_IDLE);
  assign m_we    = (st_q == XS_WRITE);
  assign m_addr  = (st_q == XS_WRITE) ? waddr_q : raddr_q;
  assign m_wdata = data_q;

  for (genvar c = 0; c < NCH; c++) begin : g_evt
    assign step_o[c] = (st_q == XS_WRITE) && m_ready && !m_err && (ch_q == IW'(c));
    assign fail_o[c] = (st_q != XS_IDLE) && m_ready && m_err && (ch_q == IW'(c));
  end

endmodule

// File: rtl/dma5_engine.sv
module dma5_engine
  import dma5_pkg::*;
#(
  parameter int NCH = 5,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int PW  = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FW  = NCH * NFLAG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [FW-1:0]  flag_set,
  input  logic [FW-1:0]  flag_clr,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           m_valid,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_ready,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_err,
  output logic [FW-1:0]  flags,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] chan_en
);

  logic           rst_s1, rst_s2, core_rst_n;
  logic [NCH-1:0] elig, step_vec, fail_vec;
  logic [PW-1:0]  prio_arr [NCH];
  logic [AW-1:0]  src_arr  [NCH];
  logic [AW-1:0]  dst_arr  [NCH];
  logic           gnt_valid;
  logic [CHW-1:0] gnt_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign core_rst_n = rst_s2;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma5_chan #(.AW(AW), .CW(CW), .PW(PW)) u_chan (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .cfg_we    (cfg_wr && (cfg_ch == CHW'(c))),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .hw_req    (dreq[c]),
      .step      (step_vec[c]),
      .fail      (fail_vec[c]),
      .flag_set  (flag_set[c*NFLAG +: NFLAG]),
      .flag_clr  (flag_clr[c*NFLAG +: NFLAG]),
      .elig_o    (elig[c]),
      .prio_o    (prio_arr[c]),
      .src_o     (src_arr[c]),
      .dst_o     (dst_arr[c]),
      .flags_o   (flags[c*NFLAG +: NFLAG]),
      .irq_o     (irq[c]),
      .en_o      (chan_en[c])
    );
  end

  dma5_arb #(.NCH(NCH), .PW(PW)) u_arb (
    .elig_i    (elig),
    .prio_i    (prio_arr),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  dma5_xfer #(.NCH(NCH), .AW(AW), .DW(DW)) u_xfer (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .src_i     (src_arr),
    .dst_i     (dst_arr),
    .m_valid   (m_valid),
    .m_we      (m_we),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .m_ready   (m_ready),
    .m_rdata   (m_rdata),
    .m_err     (m_err),
    .step_o    (step_vec),
    .fail_o    (fail_vec)
  );

  assign dack = step_vec;

endmodule

// File: rtl/dma5_engine_chk.sv
module dma5_engine_chk #(
  parameter int NCH = 5,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_wr,
  input logic           m_valid,
  input logic           m_we,
  input logic [AW-1:0]  m_addr,
  input logic           m_ready,
  input logic           m_err,
  input logic [NCH-1:0] dack,
  input logic [NCH-1:0] step_vec,
  input logic [NCH-1:0] fail_vec,
  input logic [NCH-1:0] chan_en
);

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we))); // R4

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_vec | fail_vec)); // R5

  AST_ACK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (m_valid && m_we && m_ready && !m_err)); // R3

  AST_ERR_ENDS_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_err) |=> !m_valid); // R10

  AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fail_vec) && !cfg_wr) |=> ((chan_en & $past(fail_vec)) == '0)); // R10

endmodule

bind dma5_engine dma5_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .m_valid  (m_valid),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_ready  (m_ready),
  .m_err    (m_err),
  .dack     (dack),
  .step_vec (step_vec),
  .fail_vec (fail_vec),
  .chan_en  (chan_en)
);

// File: tb/dma5_engine_test.sv
module dma5_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 5;

  logic        clk, rst_n, cfg_wr, m_valid, m_we, m_ready, m_err;
  logic [2:0]  cfg_ch;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata, m_addr, m_wdata, m_rdata;
  logic [14:0] flag_set, flag_clr, flags;
  logic [4:0]  dreq, dack, irq, chan_en;

  int tests, fails, nw;
  int pend [NCH];
  int served [NCH];
  logic [31:0] wa [1024];
  logic [31:0] wd [1024];
  logic [31:0] err_addr;
  logic        err_on;

  dma5_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .flag_set(flag_set), .flag_clr(flag_clr), .dreq(dreq),
    .dack(dack), .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err), .flags(flags), .irq(irq),
    .chan_en(chan_en)
  );

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [31:0] mk_ctrl(bit en, int dir, int pr, bit si, bit di,
                                          bit circ, logic [2:0] ie);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[2:1] = dir[1:0]; w[4:3] = pr[1:0];
    w[5] = si; w[6] = di; w[7] = circ; w[10:8] = ie;
    return w;
  endfunction

  assign m_rdata = mem_fn(m_addr);
  assign m_err   = m_valid && err_on && (m_addr == err_addr);
  for (genvar g = 0; g < NCH; g++) begin : g_req
    assign dreq[g] = pend[g] > served[g];
  end

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    m_ready = m_valid && (($urandom % 3) != 0);
    #1;
    for (int i = 0; i < NCH; i++) if (dack[i]) served[i] = served[i] + 1;
    if (m_valid && m_ready && m_we && !m_err) begin
      wa[nw % 1024] = m_addr;
      wd[nw % 1024] = m_wdata;
      nw = nw + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(int ch, int sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = ch[2:0]; cfg_sel = sel[1:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic prog(int ch, logic [31:0] s, logic [31:0] d, int cnt, logic [31:0] ctl);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, cnt); cfg(ch, 3, ctl);
  endtask

  task automatic pulse_flags(logic [14:0] s, logic [14:0] c);
    @(negedge clk);
    flag_set = s; flag_clr = c;
    @(negedge clk);
    flag_set = '0; flag_clr = '0;
  endtask

  task automatic wait_off(logic [4:0] mask, string req);
    int n;
    n = 0;
    while (((chan_en & mask) != 0 || m_valid) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    if (n >= 5000) chk(req, 32'd0, 32'd1, "channel never finished");
  endtask

  task automatic wait_writes(int target, string req);
    int n;
    n = 0;
    while (nw < target && n < 5000) begin
      @(negedge clk); n++;
    end
    if (n >= 5000) chk(req, nw, target, "write count timeout");
  endtask

  task automatic run_all;
    int base, c5, c0;
    // R1 reset state
    repeat (4) @(negedge clk);
    chk("R1", m_valid, 0, "m_valid in reset");
    chk("R1", {17'd0, flags}, 0, "flags in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {22'd0, irq, chan_en}, 0, "irq/en after reset");
    chk("R1", m_valid, 0, "m_valid after reset");

    // R2 R4 R6 R7 R8 R11: memory-to-memory, both increments
    base = nw;
    prog(0, 32'h100, 32'h1000, 6, mk_ctrl(1, 2, 0, 1, 1, 0, 3'b111));
    wait_off(5'b00001, "R7");
    chk("R7", nw - base, 6, "m2m item count");
    for (int k = 0; k < 6; k++) begin
      chk("R6", wa[(base + k) % 1024], 32'h1000 + k, "dst stepping");
      chk("R4", wd[(base + k) % 1024], mem_fn(32'h100 + k), "data moved");
    end
    chk("R8", flags[2:0], 3'b011, "half+done after full run");
    chk("R11", irq[0], 1, "irq with enabled flags");
    chk("R7", chan_en[0], 0, "enable cleared at zero");
    pulse_flags(15'b000_000_000_000_011, 15'b000_000_000_000_011);
    chk("R11", flags[2:0], 3'b011, "set wins over clear");
    pulse_flags('0, 15'h7FFF);
    chk("R11", {29'd0, flags[2:0]}, 0, "flags cleared");
    chk("R11", irq[0], 0, "irq drops");

    // R3 R8 R6: paced channel, fixed source
    base = nw;
    prog(1, 32'h40, 32'h2000, 8, mk_ctrl(1, 0, 1, 0, 1, 0, 3'b000));
    repeat (20) @(negedge clk);
    chk("R3", nw - base, 0, "no access without request");
    pend[1] = pend[1] + 4;
    wait_writes(base + 4, "R3");
    repeat (12) @(negedge clk);
    chk("R3", nw - base, 4, "one item per request");
    chk("R8", flags[5:3], 3'b001, "half at midpoint only");
    chk("R7", chan_en[1], 1, "still enabled mid-run");
    pend[1] = pend[1] + 4;
    wait_off(5'b00010, "R3");
    chk("R3", nw - base, 8, "paced total");
    chk("R7", flags[5:3], 3'b011, "done after last");
    for (int k = 0; k < 8; k++) begin
      chk("R6", wd[(base + k) % 1024], mem_fn(32'h40), "fixed source data");
      chk("R6", wa[(base + k) % 1024], 32'h2000 + k, "dst stepping paced");
    end

    // R5 arbitration
    pulse_flags('0, 15'h7FFF);
    base = nw;
    prog(1, 32'h10, 32'h3100, 1, mk_ctrl(1, 0, 1, 0, 0, 0, 3'b000));
    prog(2, 32'h20, 32'h3200, 1, mk_ctrl(1, 1, 3, 0, 0, 0, 3'b000));
    prog(3, 32'h30, 32'h3300, 1, mk_ctrl(1, 0, 3, 0, 0, 0, 3'b000));
    prog(4, 32'h40, 32'h3400, 1, mk_ctrl(1, 1, 0, 0, 0, 0, 3'b000));
    @(negedge clk);
    for (int c = 1; c < NCH; c++) pend[c] = pend[c] + 1;
    wait_writes(base + 4, "R5");
    chk("R5", wa[base % 1024], 32'h3200, "first winner high level low number");
    chk("R5", wa[(base + 1) % 1024], 32'h3300, "second winner tie");
    chk("R5", wa[(base + 2) % 1024], 32'h3100, "third winner");
    chk("R5", wa[(base + 3) % 1024], 32'h3400, "lowest level last");

    // R9 circular
    wait_off(5'b11110, "R5");
    base = nw;
    prog(4, 32'h500, 32'h4000, 3, mk_ctrl(1, 2, 0, 1, 1, 1, 3'b000));
    wait_writes(base + 7, "R9");
    cfg(4, 3, mk_ctrl(0, 2, 0, 1, 1, 1, 3'b000));
    wait_off(5'b10000, "R9");
    for (int k = 0; k < 7; k++) begin
      chk("R9", wa[(base + k) % 1024], 32'h4000 + (k % 3), "circular dst reload");
      chk("R9", wd[(base + k) % 1024], mem_fn(32'h500 + (k % 3)), "circular src reload");
    end
    chk("R9", flags[13], 1, "done in circular");

    // R10 error on one channel, another keeps going
    base = nw;
    err_addr = 32'h602; err_on = 1'b1;
    prog(0, 32'h600, 32'h5000, 5, mk_ctrl(1, 2, 3, 1, 1, 0, 3'b100));
    prog(2, 32'h700, 32'h6000, 4, mk_ctrl(1, 2, 0, 1, 1, 0, 3'b000));
    wait_off(5'b00101, "R10");
    err_on = 1'b0;
    c5 = 0; c0 = 0;
    for (int k = base; k < nw; k++) begin
      if (wa[k % 1024][15:12] == 4'h5) c5++;
      if (wa[k % 1024][15:12] == 4'h6) c0++;
    end
    chk("R10", c5, 2, "writes before error");
    chk("R10", {29'd0, flags[2:0]}, 3'b100, "error flag only");
    chk("R10", irq[0], 1, "error irq");
    chk("R10", c0, 4, "other channel unaffected");
    chk("R10", flags[7], 1, "other channel done");

    // R11 masking of software-set flag
    pulse_flags('0, 15'h7FFF);
    pulse_flags(15'b000_001_000_000_000, '0);
    chk("R11", flags[9], 1, "software set half ch3");
    chk("R11", irq[3], 0, "masked irq");
    cfg(3, 3, mk_ctrl(0, 0, 0, 0, 0, 0, 3'b001));
    @(negedge clk);
    chk("R11", irq[3], 1, "unmasked irq");
    pulse_flags('0, 15'b000_001_000_000_000);
    chk("R11", irq[3], 0, "irq after clear");

    // R7 zero count
    base = nw;
    cfg(1, 2, 0);
    cfg(1, 3, mk_ctrl(1, 2, 0, 1, 1, 0, 3'b000));
    repeat (30) @(negedge clk);
    chk("R7", nw - base, 0, "zero count idle");
    chk("R7", chan_en[1], 1, "zero count stays enabled");
    cfg(1, 3, 0);

    // R4 R6 R7 random memory-to-memory runs
    for (int r = 0; r < 8; r++) begin
      int ch, cnt;
      bit si, di;
      logic [31:0] s, d;
      ch  = $urandom % NCH;
      cnt = 1 + ($urandom % 12);
      si  = $urandom % 2;
      di  = $urandom % 2;
      s   = 32'h800 + r * 32'h40;
      d   = 32'h8000 + r * 32'h100;
      base = nw;
      prog(ch, s, d, cnt, mk_ctrl(1, 2, $urandom % 4, si, di, 0, 3'b000));
      wait_off(5'b11111, "R7");
      chk("R7", nw - base, cnt, "random item count");
      for (int k = 0; k < cnt; k++) begin
        chk("R6", wa[(base + k) % 1024], d + (di ? k : 0), "random dst");
        chk("R4", wd[(base + k) % 1024], mem_fn(s + (si ? k : 0)), "random data");
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    tests = 0; fails = 0; nw = 0;
    for (int i = 0; i < NCH; i++) begin pend[i] = 0; served[i] = 0; end
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
    flag_set = '0; flag_clr = '0; m_ready = 1'b0; err_addr = '0; err_on = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule